// File: doc/BRIEF.md
# Bus-Master DMA Controller

This block moves a block of words between one peripheral and memory without the processor touching each word. Software sets it up through a small register port. A chip-select strobe and a two-bit register index pick the start address, the number of words, or the control word. Setting the start bit with a nonzero word count arms the controller. It then waits for the peripheral's request, asks the processor for the memory bus with a bus-request line, and drives no memory cycle until the processor answers with bus grant.

Two pacing modes are offered. In burst mode the controller keeps the bus from the first word to the last. In cycle-stealing mode it releases the bus after every word and asks for it again for the next one. The direction bit selects one of two paths. In one, the peripheral drives a word onto the data path while it sees the acknowledge, and that word is written to memory. In the other, a word read from memory is presented to the peripheral together with the acknowledge. When the count runs out, the controller drops its bus request and sets a done flag, which can also raise an interrupt line.

Top module: `dma_busmaster`

## Requirements
- R1: Register index 0 is the memory address, 1 is the word count, 2 is control. A read (select high, write low) returns the register one clock later on `cpu_rdata`. The control read layout is: bit 0 start, bit 1 direction (1 = peripheral to memory), bit 2 burst (1 = burst, 0 = cycle stealing), bit 3 interrupt enable, bit 4 done. After reset all registers read 0.
- R2: While idle, writing control with bit 0 set and a nonzero count starts a transfer. With a zero count, the same write sets done at once, leaves start at 0 and never raises `bus_req`.
- R3: `bus_req` rises only after `dreq` is seen while armed. `mem_en` and `dack` stay low unless `bus_req` and `bus_grant` are both high.
- R4: For peripheral-to-memory transfers, `per_wdata` is written at `mem_addr` in the cycle where `dack` is high. For memory-to-peripheral transfers, the word read from the current address is on `per_rdata` while `dack` is high.
- R5: In burst mode, a whole block that has a continuous grant uses a single `bus_req` assertion.
- R6: In cycle-stealing mode, `bus_req` falls after every word. It rises again only once `bus_grant` is low and `dreq` is high, so a block of N words gives N request assertions.
- R7: Each word moved adds one to the address register and subtracts one from the count register.
- R8: When the count reaches zero, `bus_req` drops, done reads 1 and start reads 0.
- R9: `irq` is high while done is set and interrupt enable is 1. Any control write while idle clears done.
- R10: While a transfer is active, writes to the address and count registers, and control writes that keep bit 0 set, change nothing.
- R11: A control write with bit 0 clear during a transfer ends it at the next word boundary. An unfinished word count stays in the count register, and done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register port select |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_rs | input | 2 | Register index |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Registered read data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to peripheral, one cycle per word |
| per_wdata | input | DW | Word from peripheral (to memory) |
| per_rdata | output | DW | Word to peripheral (from memory) |
| bus_req | output | 1 | Bus request to processor |
| bus_grant | input | 1 | Bus grant from processor |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle latency |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions watch every cycle for four things. No memory cycle or acknowledge may happen without both bus ownership lines high. Each word must step the address and count by exactly one. In cycle-stealing mode the request must drop after every word, and it must also be low when done rises. Register contents must also stay frozen during a transfer except on word steps. The bench scenarios cover what needs a whole transfer to be seen: the data landing at the right addresses in both directions, the number of request assertions in each mode, the effect of a withheld grant, the zero-count start, the abort and the interrupt clearing.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_REQ,
    ST_ACCESS,
    ST_RDATA
  } dma_state_e;

  localparam logic [1:0] RS_ADDR  = 2'd0;
  localparam logic [1:0] RS_COUNT = 2'd1;
  localparam logic [1:0] RS_CTRL  = 2'd2;

  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_BURST = 2;
  localparam int CB_IE    = 3;
  localparam int CB_DONE  = 4;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_rs,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          finish,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          burst_q,
  output logic          ie_q,
  output logic          start_q,
  output logic          done_q,
  output logic          abort_q,
  output logic          go
);
  logic          wr_idle;
  logic          wr_ctrl;
  logic          cnt_zero;
  logic [DW-1:0] rd_mux;
  logic          unused_wdata;

  assign unused_wdata = ^cpu_wdata;
  assign wr_idle  = cpu_sel & cpu_wr & ~busy;
  assign wr_ctrl  = cpu_sel & cpu_wr & (cpu_rs == RS_CTRL);
  assign cnt_zero = (cnt_q == '0);
  assign go       = wr_idle && (cpu_rs == RS_CTRL) && cpu_wdata[CB_START] && !cnt_zero;

  always_comb begin
    rd_mux = '0;
    case (cpu_rs)
      RS_ADDR:  rd_mux[AW-1:0] = addr_q;
      RS_COUNT: rd_mux[CW-1:0] = cnt_q;
      RS_CTRL: begin
        rd_mux[CB_START] = start_q;
        rd_mux[CB_DIR]   = dir_q;
        rd_mux[CB_BURST] = burst_q;
        rd_mux[CB_IE]    = ie_q;
        rd_mux[CB_DONE]  = done_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      burst_q   <= 1'b0;
      ie_q      <= 1'b0;
      start_q   <= 1'b0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (wr_idle) begin
        case (cpu_rs)
          RS_ADDR:  addr_q <= cpu_wdata[AW-1:0];
          RS_COUNT: cnt_q  <= cpu_wdata[CW-1:0];
          RS_CTRL: begin
            dir_q   <= cpu_wdata[CB_DIR];
            burst_q <= cpu_wdata[CB_BURST];
            ie_q    <= cpu_wdata[CB_IE];
            start_q <= go;
            done_q  <= cpu_wdata[CB_START] & cnt_zero;
          end
          default: ;
        endcase
      end else if (step) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
      if (busy && wr_ctrl && !cpu_wdata[CB_START]) abort_q <= 1'b1;
      if (finish) begin
        start_q <= 1'b0;
        done_q  <= 1'b1;
        abort_q <= 1'b0;
      end
      if (cpu_sel && !cpu_wr) cpu_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dreq,
  input  logic          bus_grant,
  input  logic          dir_q,
  input  logic          burst_q,
  input  logic          abort_q,
  input  logic [CW-1:0] cnt_q,
  output logic          busy,
  output logic          step,
  output logic          finish,
  output logic          bus_req,
  output logic          dack,
  output logic          mem_en,
  output logic          mem_we
);
  dma_state_e st;
  logic       word_end;
  logic       last;

  always_comb begin
    word_end = ((st == ST_ACCESS) && dir_q) || (st == ST_RDATA);
    last     = abort_q || ((st == ST_ACCESS) ? (cnt_q == CW'(1)) : (cnt_q == '0));
    finish   = (word_end && last) || (((st == ST_ARM) || (st == ST_REQ)) && abort_q);
    busy     = (st != ST_IDLE);
    step     = (st == ST_ACCESS);
    mem_en   = (st == ST_ACCESS);
    mem_we   = (st == ST_ACCESS) && dir_q;
    dack     = word_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bus_req <= 1'b0;
    end else if (word_end) begin
      if (last) begin
        bus_req <= 1'b0;
        st      <= ST_IDLE;
      end else if (burst_q) begin
        st <= bus_grant ? ST_ACCESS : ST_REQ;
      end else begin
        bus_req <= 1'b0;
        st      <= ST_ARM;
      end
    end else begin
      case (st)
        ST_IDLE: if (go) st <= ST_ARM;
        ST_ARM: begin
          if (abort_q) begin
            st <= ST_IDLE;
          end else if (dreq && !bus_grant) begin
            bus_req <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (abort_q) begin
            bus_req <= 1'b0;
            st      <= ST_IDLE;
          end else if (bus_grant) begin
            st <= ST_ACCESS;
          end
        end
        ST_ACCESS: st <= ST_RDATA;
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_busmaster.sv
module dma_busmaster
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_rs,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dreq,
  output logic          dack,
  input  logic [DW-1:0] per_wdata,
  output logic [DW-1:0] per_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic dir_q, burst_q, ie_q, start_q, done_q, abort_q, go;
  logic busy, step, finish;

  dma_regfile #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rs(cpu_rs),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy), .step(step),
    .finish(finish), .addr_q(addr_q), .cnt_q(cnt_q), .dir_q(dir_q),
    .burst_q(burst_q), .ie_q(ie_q), .start_q(start_q), .done_q(done_q),
    .abort_q(abort_q), .go(go)
  );

  dma_seq #(.CW(CW)) seq_i (
    .clk(clk), .rst(rst), .go(go), .dreq(dreq), .bus_grant(bus_grant),
    .dir_q(dir_q), .burst_q(burst_q), .abort_q(abort_q), .cnt_q(cnt_q),
    .busy(busy), .step(step), .finish(finish), .bus_req(bus_req),
    .dack(dack), .mem_en(mem_en), .mem_we(mem_we)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = per_wdata;
  assign per_rdata = mem_rdata;
  assign irq       = done_q & ie_q;
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_en,
  input logic          dack,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          burst_q,
  input logic          busy,
  input logic          step,
  input logic          done_q,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q
);
  assert_drive_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (bus_req && bus_grant));

  assert_dack_owner_R4: assert property (@(posedge clk) disable iff (rst)
    dack |-> (bus_req && bus_grant));

  assert_steal_release_R6: assert property (@(posedge clk) disable iff (rst)
    (dack && !burst_q) |=> !bus_req);

  assert_word_step_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> ((addr_q == $past(addr_q) + 1'b1) && (cnt_q == $past(cnt_q) - 1'b1)));

  assert_done_drops_req_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> !bus_req);

  assert_frozen_regs_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$past(step)) |-> ($stable(addr_q) && $stable(cnt_q)));
endmodule

bind dma_busmaster dma_checker #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .mem_en(mem_en), .dack(dack), .bus_req(bus_req),
  .bus_grant(bus_grant), .burst_q(burst_q), .busy(busy), .step(step),
  .done_q(done_q), .addr_q(addr_q), .cnt_q(cnt_q)
);

// File: tb/dma_busmaster_tb_top.sv
module dma_busmaster_tb_top;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int NV = 4;
  // vector fields: {ie, dir, burst, base[7:0], count[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 8'h10, 8'd5},
    {1'b0, 1'b1, 1'b0, 8'h40, 8'd3},
    {1'b0, 1'b0, 1'b1, 8'h10, 8'd5},
    {1'b1, 1'b0, 1'b0, 8'h40, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_rs = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata, per_rdata, per_wdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic dreq = 1'b0, dack, bus_req, mem_en, mem_we, irq;
  logic bus_grant = 1'b0, grant_allow = 1'b1, clr = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] rx [16];
  int wr_idx = 0, rd_idx = 0, req_rises = 0, dack_cnt = 0;
  logic req_d = 1'b0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dma_busmaster #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rs(cpu_rs),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dreq(dreq), .dack(dack),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign per_wdata = 16'hA000 + DW'(wr_idx);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
    bus_grant <= rst ? 1'b0 : (bus_req & grant_allow);
  end

  always @(posedge clk) begin
    if (clr) begin
      wr_idx <= 0; rd_idx <= 0; req_rises <= 0; dack_cnt <= 0;
    end else begin
      if (dack && mem_we) wr_idx <= wr_idx + 1;
      if (dack && !mem_we) begin
        rx[rd_idx[3:0]] <= per_rdata;
        rd_idx <= rd_idx + 1;
      end
      if (dack) dack_cnt <= dack_cnt + 1;
      if (bus_req && !req_d) req_rises <= req_rises + 1;
    end
    req_d <= bus_req;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] rs, input logic [DW-1:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_rs = rs; cpu_wdata = d;
    @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] rs, output logic [DW-1:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_rs = rs;
    @(negedge clk); cpu_sel = 1'b0; d = cpu_rdata;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_done();
    logic [DW-1:0] r;
    for (int i = 0; i < 400; i++) begin
      cpu_read(2'd2, r);
      if (r[4]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1/R8: reset state
    chk("R1 reset bus_req", 32'(bus_req), 0);
    chk("R1 reset irq", 32'(irq), 0);
    cpu_read(2'd2, r); chk("R1 reset ctrl", 32'(r), 0);
    cpu_read(2'd0, r); chk("R1 reset addr", 32'(r), 0);

    // R1: control fields read back while idle
    cpu_write(2'd2, 16'h000E);
    cpu_read(2'd2, r); chk("R1 ctrl readback", 32'(r), 32'h0E);

    // R2: zero count start completes at once without bus request
    clear_counts();
    cpu_write(2'd1, 16'd0);
    cpu_write(2'd2, 16'h0001);
    repeat (4) @(negedge clk);
    cpu_read(2'd2, r); chk("R2 zero count ctrl", 32'(r), 32'h10);
    chk("R2 zero count no request", 32'(req_rises), 0);

    // table of transfers (R4 R5 R6 R7 R8 R9)
    dreq = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      int n;
      e = VEC[v];
      n = int'(e[7:0]);
      clear_counts();
      cpu_write(2'd0, DW'(e[15:8]));
      cpu_write(2'd1, DW'(e[7:0]));
      cpu_write(2'd2, {12'd0, e[18], e[16], e[17], 1'b1});
      wait_done();
      for (int i = 0; i < n; i++) begin
        if (e[17]) chk("R4 memory word", 32'(mem[e[15:8] + 8'(i)]), 32'h0000A000 + 32'(i));
        else chk("R4 peripheral word", 32'(rx[i]), 32'h0000A000 + 32'(i));
      end
      chk("R4 dack count", 32'(dack_cnt), 32'(n));
      if (e[16]) chk("R5 burst one request", 32'(req_rises), 1);
      else chk("R6 steal request per word", 32'(req_rises), 32'(n));
      cpu_read(2'd0, r); chk("R7 final address", 32'(r), 32'(e[15:8]) + 32'(n));
      cpu_read(2'd1, r); chk("R7 final count", 32'(r), 0);
      cpu_read(2'd2, r); chk("R8 ctrl after done", 32'(r), {27'd0, 1'b1, e[18], e[16], e[17], 1'b0});
      chk("R8 request dropped", 32'(bus_req), 0);
      chk("R9 irq level", 32'(irq), 32'(e[18]));
    end

    // R9: control write while idle clears done and irq
    cpu_write(2'd2, 16'h0000);
    @(negedge clk);
    chk("R9 irq cleared", 32'(irq), 0);

    // R10/R3: writes ignored while waiting for a withheld grant
    clear_counts();
    grant_allow = 1'b0;
    cpu_write(2'd0, 16'h0080);
    cpu_write(2'd1, 16'd2);
    cpu_write(2'd2, 16'h0007);
    repeat (4) @(negedge clk);
    chk("R3 request raised", 32'(bus_req), 1);
    chk("R3 no memory cycle without grant", 32'(mem_en), 0);
    chk("R3 no dack without grant", 32'(dack), 0);
    cpu_write(2'd0, 16'h0099);
    cpu_write(2'd1, 16'd7);
    cpu_write(2'd2, 16'h0001);
    cpu_read(2'd0, r); chk("R10 address kept", 32'(r), 32'h80);
    cpu_read(2'd1, r); chk("R10 count kept", 32'(r), 2);
    cpu_read(2'd2, r); chk("R10 ctrl kept", 32'(r), 32'h07);
    grant_allow = 1'b1;
    wait_done();
    chk("R10 words moved", 32'(wr_idx), 2);
    chk("R10 memory 0x80", 32'(mem[8'h80]), 32'hA000);
    chk("R10 memory 0x81", 32'(mem[8'h81]), 32'hA001);

    // R11: abort between stolen words
    dreq = 1'b0;
    clear_counts();
    cpu_write(2'd0, 16'h00C0);
    cpu_write(2'd1, 16'd4);
    cpu_write(2'd2, 16'h0003);
    dreq = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (dack) break;
    end
    dreq = 1'b0;
    repeat (4) @(negedge clk);
    cpu_write(2'd2, 16'h0000);
    wait_done();
    cpu_read(2'd1, r); chk("R11 remaining count", 32'(r), 3);
    cpu_read(2'd0, r); chk("R11 address", 32'(r), 32'hC1);
    cpu_read(2'd2, r); chk("R11 ctrl done", 32'(r), 32'h12);
    chk("R11 one word moved", 32'(wr_idx), 1);
    chk("R11 one request", 32'(req_rises), 1);
    chk("R11 request low", 32'(bus_req), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule